// File: doc/BRIEF.md
# Comma-Aligned Character Deserializer

This block takes a retimed serial bit stream, one bit per cycle of a fast bit clock, and assembles it into 10-bit transmission characters. It watches a sliding window of the most recent bits for the 7-bit comma pattern. When it finds the comma at a position other than the current character boundary, it moves the boundary so that the comma starts a fresh character. Each finished character goes to a staging register and is then presented on a parallel output.

The output side is timed by two complementary capture clocks that the block generates from the bit clock. Each capture clock has a period of 20 bit times and keeps running whether or not the input is valid. The parallel output updates once every 10 bit times, midway between transitions of the capture clocks. Successive characters are therefore captured on alternate rising edges of the true and complement clocks, and a downstream consumer can pair them into 20-bit half-words.

A signal-valid input freezes the assembler and the output register while it is low. The capture clocks continue during that time. Analog clock recovery, 8B/10B decoding and link synchronization are handled elsewhere.

Top module: `comma_deser`

## Requirements
- R1: The first serial bit of a character lands in `char_q[0]` and the tenth lands in `char_q[9]`, with each bit in arrival order in between.
- R2: A comma is `char_q[6:0] == 7'b1111100`, that is, two zeros received first and then five ones. When the comma shows up in the window at a position other than the current boundary, the boundary moves so that the comma occupies `char_q[6:0]`. The character holding the comma is presented within 30 bit-clock cycles of the comma's first bit.
- R3: `comma_q` is high exactly while the presented character contains the comma pattern in `char_q[6:0]`.
- R4: `cap_clk_p` and `cap_clk_n` are always complementary. Each toggles every 10 bit-clock cycles, so each has a period of 20 bit times.
- R5: `char_q` and `comma_q` change only 5 bit-clock cycles after a capture-clock transition.
- R6: Every character assembled on the established boundary is presented once, in order, for one 10-bit-time slot. Successive characters are captured on alternate rising edges of `cap_clk_p` and `cap_clk_n`. A comma that falls on the existing boundary leaves the sequence undisturbed.
- R7: While `sig_ok` is low, the outputs hold and incoming bits are discarded, even bits that form a comma, and the capture clocks keep toggling. When `sig_ok` returns high, assembly resumes on the same boundary.
- R8: The synchronous active-high reset drives `cap_clk_p` low, `cap_clk_n` high, `char_q` to zero and `comma_q` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sig_ok | input | 1 | Serial input valid; low freezes assembly and output |
| ser_in | input | 1 | Retimed serial data bit |
| char_q | output | 10 | Presented character, first received bit in bit 0 |
| comma_q | output | 1 | Presented character holds the comma pattern |
| cap_clk_p | output | 1 | True capture clock, period 20 bit times |
| cap_clk_n | output | 1 | Complement capture clock |

## Verification
The assertions check the following on every cycle:
- the capture clocks stay complementary and keep their 10-cycle half period;
- the output changes only at the midpoint slot;
- `comma_q` never appears without the pattern in `char_q[6:0]`;
- a misplaced comma resets the boundary counter;
- the assembler and output hold still while `sig_ok` is low.

Some behaviour only the bench scenarios can show: correct bit order, realignment latency for commas at several bit offsets, in-order and lossless delivery across alternate capture edges, and preservation of the boundary across a valid-low gap that carries a stray comma.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;
   localparam int unsigned CD_CHAR_W    = 10;
   localparam int unsigned CD_COMMA_W   = 7;
   localparam logic [6:0]  CD_COMMA_PAT = 7'b1111100;
endpackage

// File: rtl/cd_clkgen.sv
module cd_clkgen #(
   parameter int unsigned CHAR_W = 10
) (
   input  logic clk,
   input  logic rst,
   output logic clk_p,
   output logic clk_n,
   output logic ld
);
   localparam int unsigned PER   = 2 * CHAR_W;
   localparam int unsigned PH_W  = $clog2(PER);
   localparam int unsigned MID   = CHAR_W / 2;
   localparam int unsigned SC_W  = $clog2(CHAR_W + 1) + 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PER - 1);
   localparam logic [PH_W-1:0] PH_HALF = PH_W'(CHAR_W - 1);
   localparam logic [PH_W-1:0] LD_A    = PH_W'(MID - 1);
   localparam logic [PH_W-1:0] LD_B    = PH_W'(CHAR_W + MID - 1);

   logic [PH_W-1:0] ph_q;
   logic            flip;

   assign flip = (ph_q == PH_HALF) || (ph_q == PH_LAST);
   assign ld   = (ph_q == LD_A) || (ph_q == LD_B);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= '0;
         clk_p <= 1'b0;
         clk_n <= 1'b1;
      end else begin
         ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
         if (flip) begin
            clk_p <= ~clk_p;
            clk_n <= ~clk_n;
         end
      end
   end

   // checker: half-period counter
   logic [SC_W-1:0] since_q;
   logic            prev_p;
   always_ff @(posedge clk) begin
      if (rst) begin
         since_q <= '0;
         prev_p  <= 1'b0;
      end else begin
         since_q <= (clk_p != prev_p) ? SC_W'(1) : since_q + 1'b1;
         prev_p  <= clk_p;
      end
   end

   a_r4_complement: assert property (@(posedge clk) disable iff (rst)
      clk_p != clk_n);
   a_r4_half_period: assert property (@(posedge clk) disable iff (rst)
      !$stable(clk_p) |-> since_q == SC_W'(CHAR_W));
endmodule

// File: rtl/cd_aligner.sv
module cd_aligner #(
   parameter int unsigned          CHAR_W    = 10,
   parameter int unsigned          COMMA_W   = 7,
   parameter logic [COMMA_W-1:0]   COMMA_PAT = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sig_ok,
   input  logic              ser_in,
   output logic [CHAR_W-1:0] st_char,
   output logic              st_comma
);
   localparam int unsigned      CNT_W = $clog2(CHAR_W);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(CHAR_W - 1);

   logic [CHAR_W-1:0]  sh_q;
   logic [CHAR_W-1:0]  sh_n;
   logic [CNT_W-1:0]   cnt_q;
   logic [COMMA_W-1:0] match;
   logic               hit;
   logic               at_end;
   logic               emit;

   // newest bit enters at the top; oldest of the window sits at bit 0
   assign sh_n = {ser_in, sh_q[CHAR_W-1:1]};

   for (genvar g = 0; g < COMMA_W; g++) begin : g_match
      assign match[g] = (sh_n[g] == COMMA_PAT[g]);
   end

   assign hit    = &match;
   assign at_end = (cnt_q == LAST);
   assign emit   = at_end || hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q     <= '0;
         cnt_q    <= '0;
         st_char  <= '0;
         st_comma <= 1'b0;
      end else if (sig_ok) begin
         sh_q  <= sh_n;
         cnt_q <= emit ? '0 : cnt_q + 1'b1;
         if (emit) begin
            st_char  <= sh_n;
            st_comma <= hit;
         end
      end
   end

   // R2: a misplaced comma restarts the character count
   a_r2_realign: assert property (@(posedge clk) disable iff (rst)
      (sig_ok && hit && !at_end) |=> cnt_q == '0);
   // R7: nothing moves while the input is invalid
   a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
      !sig_ok |=> $stable(cnt_q) && $stable(sh_q) && $stable(st_char));
endmodule

// File: rtl/cd_outreg.sv
module cd_outreg #(
   parameter int unsigned        CHAR_W    = 10,
   parameter int unsigned        COMMA_W   = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld,
   input  logic              sig_ok,
   input  logic              clk_p,
   input  logic [CHAR_W-1:0] st_char,
   input  logic              st_comma,
   output logic [CHAR_W-1:0] char_q,
   output logic              comma_q
);
   localparam int unsigned MID  = CHAR_W / 2;
   localparam int unsigned SC_W = $clog2(CHAR_W + 1) + 1;

   always_ff @(posedge clk) begin
      if (rst) begin
         char_q  <= '0;
         comma_q <= 1'b0;
      end else if (ld && sig_ok) begin
         char_q  <= st_char;
         comma_q <= st_comma;
      end
   end

   // checker: cycles since the last capture-clock transition
   logic [SC_W-1:0] since_q;
   logic            prev_p;
   always_ff @(posedge clk) begin
      if (rst) begin
         since_q <= '0;
         prev_p  <= 1'b0;
      end else begin
         since_q <= (clk_p != prev_p) ? SC_W'(1) : since_q + 1'b1;
         prev_p  <= clk_p;
      end
   end

   a_r5_midpoint: assert property (@(posedge clk) disable iff (rst)
      (!$stable(char_q) || !$stable(comma_q)) |-> since_q == SC_W'(MID));
   a_r3_flag_pattern: assert property (@(posedge clk) disable iff (rst)
      comma_q |-> char_q[COMMA_W-1:0] == COMMA_PAT);
   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      !sig_ok |=> $stable(char_q) && $stable(comma_q));
endmodule

// File: rtl/comma_deser.sv
module comma_deser
   import comma_deser_pkg::*;
#(
   parameter int unsigned        CHAR_W    = CD_CHAR_W,
   parameter int unsigned        COMMA_W   = CD_COMMA_W,
   parameter logic [COMMA_W-1:0] COMMA_PAT = CD_COMMA_PAT
) (
   input  logic              clk_bit,
   input  logic              rst,
   input  logic              sig_ok,
   input  logic              ser_in,
   output logic [CHAR_W-1:0] char_q,
   output logic              comma_q,
   output logic              cap_clk_p,
   output logic              cap_clk_n
);
   if (CHAR_W % 2 != 0) begin : g_bad_even
      $error("CHAR_W must be even so the output slot sits midway");
   end
   if (CHAR_W < 4) begin : g_bad_small
      $error("CHAR_W must be at least 4");
   end
   if (COMMA_W > CHAR_W || COMMA_W < 2) begin : g_bad_comma
      $error("COMMA_W must lie between 2 and CHAR_W");
   end

   logic              ld;
   logic [CHAR_W-1:0] st_char;
   logic              st_comma;

   cd_clkgen #(.CHAR_W(CHAR_W)) u_clkgen (
      .clk   (clk_bit),
      .rst   (rst),
      .clk_p (cap_clk_p),
      .clk_n (cap_clk_n),
      .ld    (ld)
   );

   cd_aligner #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_aligner (
      .clk      (clk_bit),
      .rst      (rst),
      .sig_ok   (sig_ok),
      .ser_in   (ser_in),
      .st_char  (st_char),
      .st_comma (st_comma)
   );

   cd_outreg #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_outreg (
      .clk      (clk_bit),
      .rst      (rst),
      .ld       (ld),
      .sig_ok   (sig_ok),
      .clk_p    (cap_clk_p),
      .st_char  (st_char),
      .st_comma (st_comma),
      .char_q   (char_q),
      .comma_q  (comma_q)
   );
endmodule

// File: tb/comma_deser_bench.sv
module comma_deser_bench;
   localparam logic [9:0] COMMA_CH = 10'b0101111100;
   localparam logic [6:0] PAT      = 7'b1111100;
   localparam logic [9:0] MASK     = 10'b1011011011;

   logic       clk_bit = 1'b0;
   logic       rst     = 1'b1;
   logic       sig_ok  = 1'b0;
   logic       ser_in  = 1'b0;
   logic [9:0] char_q;
   logic       comma_q;
   logic       cap_clk_p;
   logic       cap_clk_n;

   comma_deser u_comma_deser (
      .clk_bit   (clk_bit),
      .rst       (rst),
      .sig_ok    (sig_ok),
      .ser_in    (ser_in),
      .char_q    (char_q),
      .comma_q   (comma_q),
      .cap_clk_p (cap_clk_p),
      .cap_clk_n (cap_clk_n)
   );

   always #10 clk_bit = ~clk_bit;

   int         n_chk = 0;
   int         n_bad = 0;
   int         cyc = 0;
   int         comma_t0 = -1;
   bit         armed = 0;
   bit         mon_en = 0;
   logic [9:0] expq[$];
   logic [9:0] lf = 10'h2A5;

   always @(posedge clk_bit) cyc++;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk_bit);
      ser_in = b;
   endtask

   task automatic send_char(input logic [9:0] c, input bit push);
      if (push) expq.push_back(c);
      for (int i = 0; i < 10; i++) send_bit(c[i]);
   endtask

   function automatic logic [9:0] next_data();
      lf = {lf[8:0], lf[9] ^ lf[6]};
      return (lf & MASK) | 10'b0000000001;
   endfunction

   // scoreboard monitor: capture at every capture-clock rising edge
   initial begin
      logic prev_p = 1'b0;
      logic [9:0] prev_c = '0;
      int since = 0;
      int last_rise = -1;
      forever begin
         @(negedge clk_bit);
         if (mon_en) begin
            chk(cap_clk_n == ~cap_clk_p, "R4", "clocks complementary", cap_clk_n, ~cap_clk_p);
            if (cap_clk_p != prev_p) begin
               if (cap_clk_p) begin
                  if (last_rise >= 0)
                     chk(cyc - last_rise == 20, "R4", "rise-to-rise period", cyc - last_rise, 20);
                  last_rise = cyc;
               end
               since = 0;
               if (!armed && expq.size() > 0 && char_q == expq[0]) begin
                  armed = 1;
                  if (expq[0][6:0] == PAT && comma_t0 >= 0)
                     chk(cyc - comma_t0 <= 30, "R2", "comma presentation latency", cyc - comma_t0, 30);
                  comma_t0 = -1;
               end
               if (armed) begin
                  if (expq.size() == 0) armed = 0;
                  else begin
                     logic [9:0] e;
                     e = expq.pop_front();
                     chk(char_q == e, "R1/R6", "captured character", char_q, e);
                     chk(comma_q == (e[6:0] == PAT), "R3", "comma flag", comma_q, e[6:0] == PAT);
                  end
               end
            end else begin
               since++;
            end
            if (char_q != prev_c)
               chk(since == 5, "R5", "cycles from clock edge to data change", since, 5);
         end
         prev_p = cap_clk_p;
         prev_c = char_q;
      end
   end

   task automatic run_stream(input int k, input int ndata);
      armed = 0;
      expq.delete();
      repeat (20 + k) send_bit(1'b0);
      comma_t0 = cyc + 1;
      send_char(COMMA_CH, 1);
      for (int i = 0; i < ndata; i++) begin
         if (i == 4) send_char(COMMA_CH, 1);   // R6: comma on the existing boundary
         send_char(next_data(), 1);
      end
      repeat (50) send_bit(1'b0);
      chk(expq.size() == 0, "R6", "characters left undelivered", expq.size(), 0);
   endtask

   initial begin
      logic [9:0] held;
      logic       held_c;
      int         tog;
      logic       pp;
      repeat (4) @(negedge clk_bit);
      // R8: reset state
      chk(cap_clk_p == 1'b0, "R8", "cap_clk_p in reset", cap_clk_p, 0);
      chk(cap_clk_n == 1'b1, "R8", "cap_clk_n in reset", cap_clk_n, 1);
      chk(char_q == '0, "R8", "char_q in reset", char_q, 0);
      chk(comma_q == 1'b0, "R8", "comma_q in reset", comma_q, 0);
      rst = 1'b0;
      sig_ok = 1'b1;
      mon_en = 1;

      // R1, R2: commas at several bit offsets
      run_stream(3, 8);
      run_stream(7, 8);
      run_stream(0, 8);
      run_stream(9, 8);
      run_stream(5, 8);
      run_stream(1, 8);

      // R7: valid-low gap carrying a stray comma
      armed = 0;
      expq.delete();
      repeat (13) send_bit(1'b0);
      send_char(COMMA_CH, 0);
      send_char(10'b0011011010, 0);
      @(negedge clk_bit);
      held   = char_q;
      held_c = comma_q;
      pp     = cap_clk_p;
      tog    = 0;
      sig_ok = 1'b0;
      for (int i = 0; i < 40; i++) begin
         ser_in = (i < 3) ? 1'b0 : ((i < 13) ? COMMA_CH[i-3] : 1'b0);
         @(negedge clk_bit);
         if (cap_clk_p != pp) tog++;
         pp = cap_clk_p;
         if (char_q != held || comma_q != held_c)
            chk(0, "R7", "output moved while invalid", char_q, held);
      end
      chk(char_q == held, "R7", "char held through gap", char_q, held);
      chk(tog == 4, "R7", "clock toggles during gap", tog, 4);
      expq.push_back(10'b1001001001);
      sig_ok = 1'b1;
      ser_in = 1'b1;
      for (int i = 1; i < 10; i++) send_bit(10'b1001001001 >> i);
      for (int i = 0; i < 3; i++) send_char(next_data(), 1);
      repeat (50) send_bit(1'b0);
      chk(expq.size() == 0, "R7", "boundary kept after gap", expq.size(), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_bit);
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule